// File: doc/BRIEF.md
# DMA Channel Data Mover

This block carries out a single memory-to-memory transfer for one DMA channel. A controller loads a source base address, a destination base address, a byte count, a packed configuration word and a parameter word, then pulses `start`. The mover reads beats from the source side and writes beats to the destination side over two simple request/acknowledge memory ports. It repacks data between the two sides when their beat widths differ. Each side has its own beat width, burst length and address mode. The two sides share one idle count, which is inserted after every completed burst.

A side in fixed-address (I/O) mode is paced by its peripheral request input. A new burst on that side begins only while the request input is high. The current source address, current destination address and remaining byte count are visible on output ports throughout the transfer. When the last destination beat is acknowledged, `done` pulses. Dropping `enable` parks the mover at the next beat boundary without a `done` pulse.

The controller is a six-state machine:
- `S_IDLE` moves to `S_PICK` on `start`.
- `S_PICK` decides the next step:
  - to `S_DONE` when no bytes remain;
  - back to `S_IDLE` when `enable` is low;
  - to `S_WRITE` when the staging buffer holds a destination beat;
  - to `S_READ` otherwise;
  - it stays in `S_PICK` while a gating request input is low.
- `S_READ` and `S_WRITE` each hold their request until it is acknowledged. They then move:
  - to `S_GAP` after a burst completes with a non-zero idle count;
  - to `S_PICK` otherwise;
  - `S_WRITE` goes straight to `S_DONE` after the final beat.
- `S_GAP` returns to `S_PICK` after the idle count has elapsed.
- `S_DONE` lasts one cycle and returns to `S_IDLE`.

Top module: `dmx_mover`

## Requirements
- R1: The config word is decoded as follows.
  - Destination side: beat-width code in bits 26:25, burst code in bits 23:22, address mode in bit 21, peripheral select in bits 20:16.
  - Source side: beat-width code in bits 10:9, burst code in bits 7:6, address mode in bit 5, peripheral select in bits 4:0.
  - Width code c means a beat of 2^c bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes).
  - The two selects appear on `src_sel`/`dst_sel` after `start`.
- R2: Burst codes 0, 1, 2 and 3 mean 1, 4, 8 and 16 beats per burst on that side.
- R3: In linear mode (address-mode bit 0), a side's address starts at its base and advances by its beat size after each acknowledged beat. `cur_src` and `cur_dst` show these addresses.
- R4: In I/O mode (address-mode bit 1), a side's address stays at its base for the whole transfer.
- R5: Data is repacked little-endian across the two sides. The first source byte lands in `wr_data[7:0]` of the first write. Lanes above the destination beat size are zero. The staging buffer never overflows.
- R6: In I/O mode, a side starts a new burst only while its request input (`src_drq`/`dst_drq`) is high. In linear mode the request input is ignored.
- R7: After each completed burst on either side, the mover issues no request for `param_word[7:0]` cycles. No pause follows the final write.
- R8: `bytes_left` loads with `byte_count` on `start` and drops by the destination beat size on each acknowledged write. When it reaches zero, `done` is high for exactly one cycle.
- R9: With `enable` low, a request already in flight completes. The mover then returns to idle with `busy` low, issues no further requests, raises no `done`, and keeps `bytes_left`.
- R10: `start` is ignored while `busy` is high. A start with a byte count of zero gives a `done` pulse and no memory requests.
- R11: After reset, `busy`, `done`, `rd_req` and `wr_req` are low and `bytes_left` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load the transfer and begin (idle only) |
| enable | input | 1 | Run permission; low parks at a beat boundary |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| byte_count | input | CW | Bytes to move |
| cfg_word | input | 32 | Packed per-side configuration |
| param_word | input | 32 | Bits 7:0 give the idle count between bursts |
| src_drq | input | 1 | Source peripheral request |
| dst_drq | input | 1 | Destination peripheral request |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_bytes | output | 4 | Read beat size in bytes |
| rd_ack | input | 1 | Read acknowledge with data |
| rd_data | input | 64 | Read data, byte 0 in bits 7:0 |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | AW | Write address |
| wr_bytes | output | 4 | Write beat size in bytes |
| wr_data | output | 64 | Write data, unused lanes zero |
| wr_ack | input | 1 | Write acknowledge |
| src_sel | output | 5 | Decoded source peripheral select |
| dst_sel | output | 5 | Decoded destination peripheral select |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| bytes_left | output | CW | Bytes still to be written |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the mover with its defaults: 32-bit addresses and a 24-bit byte counter. This makes a 64-byte transfer and every width and burst code reachable in a few hundred cycles. The bench uses a memory model that acknowledges one half-cycle after each request. It compares every write against a byte stream derived from the source addresses. The idle-count rule is measured as a difference in start-to-done cycles between runs with and without idle cycles.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_READ,
        S_WRITE,
        S_GAP,
        S_DONE
    } mv_state_e;

    typedef struct packed {
        logic [1:0] wcode;
        logic [1:0] bcode;
        logic       io;
        logic [4:0] sel;
    } side_cfg_t;

    localparam int NSIDE    = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;
    localparam int LANES    = 8;

    function automatic logic [3:0] beat_bytes(input logic [1:0] wcode);
        beat_bytes = 4'd1 << wcode;
    endfunction

    function automatic logic [3:0] burst_last(input logic [1:0] bcode);
        unique case (bcode)
            2'd0:    burst_last = 4'd0;
            2'd1:    burst_last = 4'd3;
            2'd2:    burst_last = 4'd7;
            default: burst_last = 4'd15;
        endcase
    endfunction

    function automatic logic [63:0] lane_mask(input logic [3:0] nbytes);
        if (nbytes >= 4'd8)
            lane_mask = '1;
        else
            lane_mask = (64'd1 << {nbytes, 3'b000}) - 64'd1;
    endfunction

endpackage

// File: rtl/dmx_cfg_decode.sv
module dmx_cfg_decode
    import dmx_pkg::*;
(
    input  logic [31:0] cfg_word,
    input  logic [31:0] param_word,
    output side_cfg_t   src_cfg,
    output side_cfg_t   dst_cfg,
    output logic [7:0]  wait_cycles
);

    logic unused_cfg_bits;

    always_comb begin
        dst_cfg.wcode = cfg_word[26:25];
        dst_cfg.bcode = cfg_word[23:22];
        dst_cfg.io    = cfg_word[21];
        dst_cfg.sel   = cfg_word[20:16];
        src_cfg.wcode = cfg_word[10:9];
        src_cfg.bcode = cfg_word[7:6];
        src_cfg.io    = cfg_word[5];
        src_cfg.sel   = cfg_word[4:0];
        wait_cycles   = param_word[7:0];
    end

    assign unused_cfg_bits = ^{cfg_word[31:27], cfg_word[24], cfg_word[15:11],
                               cfg_word[8], param_word[31:8]};

endmodule

// File: rtl/dmx_addr_trk.sv
module dmx_addr_trk #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          fixed,
    input  logic [3:0]    nbytes,
    output logic [AW-1:0] addr
);

    localparam int PADW = AW - 4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step && !fixed)
            addr <= addr + {{PADW{1'b0}}, nbytes};
    end

endmodule

// File: rtl/dmx_pack_buf.sv
module dmx_pack_buf
    import dmx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        push,
    input  logic [63:0] push_data,
    input  logic [3:0]  push_bytes,
    input  logic        pop,
    input  logic [3:0]  pop_bytes,
    output logic [3:0]  fill,
    output logic [63:0] head
);

    logic [63:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            fill    <= '0;
        end else if (clear) begin
            stage_q <= '0;
            fill    <= '0;
        end else if (push) begin
            stage_q <= stage_q | ((push_data & lane_mask(push_bytes)) << {fill, 3'b000});
            fill    <= fill + push_bytes;
        end else if (pop) begin
            stage_q <= stage_q >> {pop_bytes, 3'b000};
            fill    <= fill - pop_bytes;
        end
    end

    assign head = stage_q;

endmodule

// File: rtl/dmx_mover.sv
module dmx_mover
    import dmx_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          enable,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] byte_count,
    input  logic [31:0]   cfg_word,
    input  logic [31:0]   param_word,
    input  logic          src_drq,
    input  logic          dst_drq,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [3:0]    rd_bytes,
    input  logic          rd_ack,
    input  logic [63:0]   rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [3:0]    wr_bytes,
    output logic [63:0]   wr_data,
    input  logic          wr_ack,
    output logic [4:0]    src_sel,
    output logic [4:0]    dst_sel,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] bytes_left,
    output logic          busy,
    output logic          done
);

    localparam int CPAD = CW - 4;

    mv_state_e  state, state_nx;
    side_cfg_t  src_cfg_d, dst_cfg_d, src_q, dst_q;
    logic [7:0] wait_d, wait_q, gap_cnt;
    logic [3:0] src_beat, dst_beat, ssz, dsz, fill;
    logic [63:0] head;
    logic       load, rd_done, wr_done, src_wrap, dst_wrap, last_wr;
    logic       src_io_q, dst_io_q;
    logic [CW-1:0] left_after;

    dmx_cfg_decode u_dec (
        .cfg_word    (cfg_word),
        .param_word  (param_word),
        .src_cfg     (src_cfg_d),
        .dst_cfg     (dst_cfg_d),
        .wait_cycles (wait_d)
    );

    assign load     = (state == S_IDLE) && start;
    assign rd_done  = (state == S_READ) && rd_ack;
    assign wr_done  = (state == S_WRITE) && wr_ack;
    assign ssz      = beat_bytes(src_q.wcode);
    assign dsz      = beat_bytes(dst_q.wcode);
    assign src_wrap = (src_beat == burst_last(src_q.bcode));
    assign dst_wrap = (dst_beat == burst_last(dst_q.bcode));
    assign left_after = bytes_left - {{CPAD{1'b0}}, dsz};
    assign last_wr  = (left_after == '0);
    assign src_io_q = src_q.io;
    assign dst_io_q = dst_q.io;

    // one address tracker per side
    logic [AW-1:0] trk_base  [NSIDE];
    logic          trk_step  [NSIDE];
    logic          trk_fixed [NSIDE];
    logic [3:0]    trk_bytes [NSIDE];
    logic [AW-1:0] trk_addr  [NSIDE];

    assign trk_base[SIDE_SRC]  = src_base;
    assign trk_base[SIDE_DST]  = dst_base;
    assign trk_step[SIDE_SRC]  = rd_done;
    assign trk_step[SIDE_DST]  = wr_done;
    assign trk_fixed[SIDE_SRC] = src_q.io;
    assign trk_fixed[SIDE_DST] = dst_q.io;
    assign trk_bytes[SIDE_SRC] = ssz;
    assign trk_bytes[SIDE_DST] = dsz;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dmx_addr_trk #(.AW(AW)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .base   (trk_base[g]),
            .step   (trk_step[g]),
            .fixed  (trk_fixed[g]),
            .nbytes (trk_bytes[g]),
            .addr   (trk_addr[g])
        );
    end

    assign cur_src = trk_addr[SIDE_SRC];
    assign cur_dst = trk_addr[SIDE_DST];

    dmx_pack_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load),
        .push       (rd_done),
        .push_data  (rd_data),
        .push_bytes (ssz),
        .pop        (wr_done),
        .pop_bytes  (dsz),
        .fill       (fill),
        .head       (head)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_PICK;
            S_PICK: begin
                if (bytes_left == '0)
                    state_nx = S_DONE;
                else if (!enable)
                    state_nx = S_IDLE;
                else if (fill >= dsz) begin
                    if (!(dst_q.io && dst_beat == 4'd0 && !dst_drq))
                        state_nx = S_WRITE;
                end else begin
                    if (!(src_q.io && src_beat == 4'd0 && !src_drq))
                        state_nx = S_READ;
                end
            end
            S_READ: begin
                if (rd_ack)
                    state_nx = (src_wrap && wait_q != 8'd0) ? S_GAP : S_PICK;
            end
            S_WRITE: begin
                if (wr_ack) begin
                    if (last_wr)
                        state_nx = S_DONE;
                    else
                        state_nx = (dst_wrap && wait_q != 8'd0) ? S_GAP : S_PICK;
                end
            end
            S_GAP:   if (gap_cnt == 8'd1) state_nx = S_PICK;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_req   = (state == S_READ);
        wr_req   = (state == S_WRITE);
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        rd_addr  = cur_src;
        wr_addr  = cur_dst;
        rd_bytes = ssz;
        wr_bytes = dsz;
        wr_data  = head & lane_mask(dsz);
        src_sel  = src_q.sel;
        dst_sel  = dst_q.sel;
    end

    // transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= '0;
            dst_q      <= '0;
            wait_q     <= '0;
            bytes_left <= '0;
            src_beat   <= '0;
            dst_beat   <= '0;
            gap_cnt    <= '0;
        end else begin
            if (load) begin
                src_q      <= src_cfg_d;
                dst_q      <= dst_cfg_d;
                wait_q     <= wait_d;
                bytes_left <= byte_count;
                src_beat   <= '0;
                dst_beat   <= '0;
            end
            if (rd_done)
                src_beat <= src_wrap ? 4'd0 : src_beat + 4'd1;
            if (wr_done) begin
                dst_beat   <= dst_wrap ? 4'd0 : dst_beat + 4'd1;
                bytes_left <= left_after;
            end
            if (state_nx == S_GAP && state != S_GAP)
                gap_cnt <= wait_q;
            else if (state == S_GAP)
                gap_cnt <= gap_cnt - 8'd1;
        end
    end

endmodule

// File: rtl/dmx_mover_chk.sv
module dmx_mover_chk #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          busy,
    input logic          rd_req,
    input logic          rd_ack,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [3:0]    rd_bytes,
    input logic [3:0]    fill,
    input logic          src_drq,
    input logic          src_io_q,
    input logic [3:0]    src_beat,
    input logic          dst_io_q,
    input logic [AW-1:0] cur_dst,
    input logic [CW-1:0] bytes_left,
    input logic [3:0]    dsz
);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_left_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> (bytes_left == $past(bytes_left) - CW'($past(dsz))));

    p_fixed_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dst_io_q) |-> $stable(cur_dst));

    p_drq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && src_io_q && src_beat == 4'd0) |-> $past(src_drq));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ({1'b0, fill} + {1'b0, rd_bytes} <= 5'd8));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req);

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

endmodule

bind dmx_mover dmx_mover_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .busy       (busy),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .wr_req     (wr_req),
    .wr_ack     (wr_ack),
    .rd_bytes   (rd_bytes),
    .fill       (fill),
    .src_drq    (src_drq),
    .src_io_q   (src_io_q),
    .src_beat   (src_beat),
    .dst_io_q   (dst_io_q),
    .cur_dst    (cur_dst),
    .bytes_left (bytes_left),
    .dsz        (dsz)
);

// File: tb/dmx_mover_bench.sv
module dmx_mover_bench;

    localparam int AW = 32;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, enable = 1'b1;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic [CW-1:0] byte_count = '0;
    logic [31:0]   cfg_word = '0, param_word = '0;
    logic          src_drq = 1'b1, dst_drq = 1'b1;
    logic          rd_req, wr_req, rd_ack = 1'b0, wr_ack = 1'b0;
    logic [AW-1:0] rd_addr, wr_addr, cur_src, cur_dst;
    logic [3:0]    rd_bytes, wr_bytes;
    logic [63:0]   rd_data, wr_data;
    logic [4:0]    src_sel, dst_sel;
    logic [CW-1:0] bytes_left;
    logic          busy, done;

    dmx_mover #(.AW(AW), .CW(CW)) u_dmx_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
        .src_base(src_base), .dst_base(dst_base), .byte_count(byte_count),
        .cfg_word(cfg_word), .param_word(param_word),
        .src_drq(src_drq), .dst_drq(dst_drq),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
        .rd_ack(rd_ack), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
        .wr_data(wr_data), .wr_ack(wr_ack),
        .src_sel(src_sel), .dst_sel(dst_sel),
        .cur_src(cur_src), .cur_dst(cur_dst), .bytes_left(bytes_left),
        .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int n_run = 0, n_fail = 0, cyc = 0;
    int done_cnt = 0, wcount = 0, rd_seen = 0;
    logic [31:0] t_sb, t_db;
    int t_ssz = 1, t_dsz = 1;
    bit t_sio = 0, t_dio = 0;

    function automatic logic [7:0] src_byte(input logic [31:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mk_cfg(input int sw, input int sb, input bit sio, input int ss,
                                           input int dw, input int db, input bit dio, input int ds);
        return (32'(dw) << 25) | (32'(db) << 22) | (32'(dio) << 21) | (32'(ds) << 16) |
               (32'(sw) << 9) | (32'(sb) << 6) | (32'(sio) << 5) | 32'(ss);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model: acknowledge half a cycle after a request
    always_comb begin
        for (int i = 0; i < 8; i++)
            rd_data[i*8 +: 8] = src_byte(rd_addr + 32'(i));
    end

    always @(negedge clk) begin
        rd_ack <= rd_req && !rd_ack;
        wr_ack <= wr_req && !wr_ack;
    end

    // per-write checks of address and data (R3 R4 R5)
    always @(negedge clk) begin
        if (rd_req) rd_seen++;
        if (done) done_cnt++;
        if (wr_req && !wr_ack) begin
            logic [63:0] exp_d;
            logic [31:0] exp_a;
            exp_d = '0;
            for (int i = 0; i < t_dsz; i++) begin
                int k;
                k = wcount * t_dsz + i;
                exp_d[i*8 +: 8] = src_byte(t_sio ? t_sb + 32'(k % t_ssz) : t_sb + 32'(k));
            end
            exp_a = t_dio ? t_db : t_db + 32'(wcount * t_dsz);
            check(wr_addr == exp_a, "R3/R4 write address", 64'(wr_addr), 64'(exp_a));
            check(wr_data == exp_d, "R5 write data", wr_data, exp_d);
            wcount++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // load and start; returns cycles until done (or until idle)
    task automatic launch(input logic [31:0] sb, input logic [31:0] db, input int cnt,
                          input logic [31:0] cfg, input int wt, output int cycles);
        t_sb = sb; t_db = db;
        t_ssz = 1 << cfg[10:9]; t_dsz = 1 << cfg[26:25];
        t_sio = cfg[5]; t_dio = cfg[21];
        wcount = 0; done_cnt = 0; rd_seen = 0;
        @(negedge clk);
        src_base = sb; dst_base = db; byte_count = CW'(cnt);
        cfg_word = cfg; param_word = 32'(wt) | 32'hABCD_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
    endtask

    task automatic wait_end(inout int cycles);
        while (!done && busy && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset;
        check(!busy && !done && !rd_req && !wr_req, "R11 idle outputs",
              64'({busy, done, rd_req, wr_req}), 64'd0);
        check(bytes_left == '0, "R11 bytes_left", 64'(bytes_left), 64'd0);
    endtask

    task automatic t_linear;
        int c;
        src_drq = 1'b0; dst_drq = 1'b0;   // ignored in linear mode (R6)
        launch(32'h1000, 32'h2000, 16, mk_cfg(2, 0, 0, 5'd3, 2, 0, 0, 5'd17), 0, c);
        check(src_sel == 5'd3 && dst_sel == 5'd17, "R1 select fields",
              64'({src_sel, dst_sel}), 64'({5'd3, 5'd17}));
        check(bytes_left == CW'(16), "R8 load count", 64'(bytes_left), 64'd16);
        wait_end(c);
        check(done == 1'b1, "R6 linear ignores drq / R8 done", 64'(done), 64'd1);
        @(negedge clk);
        check(!done && !busy, "R8 done one cycle", 64'({done, busy}), 64'd0);
        check(cur_src == 32'h1010 && cur_dst == 32'h2010, "R3 final addresses",
              64'({cur_src, cur_dst}), 64'({32'h1010, 32'h2010}));
        check(wcount == 4 && bytes_left == '0, "R8 write count", 64'(wcount), 64'd4);
        src_drq = 1'b1; dst_drq = 1'b1;
    endtask

    task automatic t_narrow_to_wide;
        int c;
        launch(32'h3001, 32'h4000, 8, mk_cfg(0, 0, 0, 0, 2, 0, 0, 0), 0, c);
        repeat (5) @(negedge clk);
        c += 5;
        start = 1'b1;                      // R10 ignored while busy
        src_base = 32'h9999; dst_base = 32'h8888;
        @(negedge clk);
        start = 1'b0;
        c++;
        wait_end(c);
        check(done_cnt + (done ? 1 : 0) >= 1 && wcount == 2, "R10 busy start ignored / R5 packing",
              64'(wcount), 64'd2);
        @(negedge clk);
        check(cur_src == 32'h3009, "R1 R3 byte-wide source step", 64'(cur_src), 64'h3009);
        check(!busy, "R10 returns idle", 64'(busy), 64'd0);
    endtask

    task automatic t_wide_to_fixed;
        int c;
        launch(32'h5000, 32'h6000, 16, mk_cfg(3, 0, 0, 0, 1, 0, 1, 0), 0, c);
        wait_end(c);
        @(negedge clk);
        check(cur_dst == 32'h6000, "R4 fixed destination", 64'(cur_dst), 64'h6000);
        check(cur_src == 32'h5010 && wcount == 8, "R1 R5 64-bit to 16-bit split",
              64'({cur_src, 32'(wcount)}), 64'({32'h5010, 32'd8}));
    endtask

    task automatic t_drq_gate;
        int c;
        src_drq = 1'b0;
        launch(32'h7000, 32'h7800, 8, mk_cfg(2, 0, 1, 0, 2, 0, 0, 0), 0, c);
        repeat (20) @(negedge clk);
        c += 20;
        check(rd_seen == 0 && busy, "R6 source stalled by request", 64'(rd_seen), 64'd0);
        src_drq = 1'b1;
        wait_end(c);
        @(negedge clk);
        check(wcount == 2 && cur_src == 32'h7000, "R6 R4 completes after request",
              64'({32'(wcount), cur_src}), 64'({32'd2, 32'h7000}));
    endtask

    task automatic t_wait;
        int c0, c5;
        logic [31:0] cf;
        cf = mk_cfg(2, 1, 0, 0, 2, 1, 0, 0);
        launch(32'h100, 32'h900, 32, cf, 0, c0);
        wait_end(c0);
        @(negedge clk);
        launch(32'h100, 32'h900, 32, cf, 5, c5);
        wait_end(c5);
        @(negedge clk);
        check(c5 - c0 == 15, "R7 R2 idle cycles after bursts", 64'(c5 - c0), 64'd15);
    endtask

    task automatic t_halt;
        int c;
        launch(32'hA000, 32'hB000, 64, mk_cfg(2, 0, 0, 0, 2, 0, 0, 0), 0, c);
        while (wcount < 3 && c < 5000) begin @(negedge clk); c++; end
        enable = 1'b0;
        while (busy && c < 5000) begin @(negedge clk); c++; end
        check(!busy && done_cnt == 0, "R9 halt without done", 64'({busy, 32'(done_cnt)}), 64'd0);
        check(bytes_left == CW'(64 - 4 * wcount) && bytes_left != '0, "R9 bytes kept",
              64'(bytes_left), 64'(64 - 4 * wcount));
        rd_seen = 0;
        repeat (10) @(negedge clk);
        check(rd_seen == 0 && !wr_req, "R9 no requests after halt", 64'(rd_seen), 64'd0);
        enable = 1'b1;
    endtask

    task automatic t_zero;
        int c;
        launch(32'hC000, 32'hD000, 0, mk_cfg(2, 0, 0, 0, 2, 0, 0, 0), 0, c);
        wait_end(c);
        check(done && rd_seen == 0 && wcount == 0, "R10 zero count done",
              64'({done, 32'(rd_seen)}), 64'({1'b1, 32'd0}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_linear;
        t_narrow_to_wide;
        t_wide_to_fixed;
        t_drq_gate;
        t_wait;
        t_halt;
        t_zero;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule